// File: doc/BRIEF.md
# Ethernet Test Frame Generator

The generator produces a continuous train of synthetic Ethernet frames for hardware self-test of a transmit path. Software loads one or more short header templates in 16-bit words and programs a header length and a total frame length. It then drives a single control word that carries an interframe gap, a template select, a frame mode and an enable bit. While enabled, the block sends each frame as a byte stream: the template bytes first, then an incrementing payload counter. It stops four bytes short of the programmed length so that a downstream MAC can append the FCS. Each frame is followed by a fixed number of idle cycles. In corrupt mode the final byte of every frame is inverted and flagged so that the downstream checksum comes out wrong.

The control word has separate valid bits for the gap/select pair and for the mode. A write can therefore change only the mode while generation keeps running. All settings are captured at the start of each frame, so a change that arrives mid-frame applies from the next frame on. A disable lets the current frame finish. A 16-bit counter of completed frames is brought out so that a test can compare it with the number of frames it received.

The output is valid/ready. A byte transfers on a clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the block holds `out_valid`, `out_data`, `out_last` and `out_err` unchanged. Once raised, `out_valid` never drops before the byte is taken. Back-pressure only stretches a frame; it never drops or repeats a byte.

Top module: `testfrm_gen`

## Requirements
- R1: After reset `out_valid` is 0, `frame_cnt` is 0 and `len_rej` is 0. The staged settings are gap 12, template 0, mode 0, disabled, header length 14 and frame length 64.
- R2: The first `hdr_len` bytes of a frame come from the selected template. Template `s` word `w` is written at `tpl_addr = s*16 + w` (with the default 16 words per template). Its bits [15:8] are header byte 2w and its bits [7:0] are header byte 2w+1.
- R3: After the header, payload bytes count 0, 1, 2, ... modulo 256, restarting at 0 in every frame. A frame is exactly `frame_len - 4` bytes long, and `out_last` is high on its final byte only.
- R4: A length write (`len_we`) is accepted only if the header length is even and at most 32, and the frame length is between 64 and 1024 inclusive. Otherwise `len_rej` is high in the following cycle and the previous lengths stay in force. An accepted write leaves `len_rej` low.
- R5: The fields of `ctrl_wdata` are: gap in bits [15:0], template select in bits [17:16], mode in bits [19:18], config-valid in bit 20, mode-valid in bit 21 and enable in bit 22. Gap and select are updated only when bit 20 is set. Mode is updated only when bit 21 is set. Enable is updated on every write.
- R6: With mode 1, the last byte of each frame is bit-inverted and `out_err` is high with it. With modes 0, 2 and 3, frames are unmodified and `out_err` stays 0.
- R7: After the last byte of a frame is accepted, `out_valid` stays low for exactly `gap` cycles. If the block is still enabled, the next frame's first byte is then valid. A gap of 0 gives back-to-back frames.
- R8: Settings written during a frame, including the mode, apply from the next frame. A disable during a frame lets that frame complete, and after it no further byte is offered.
- R9: While `out_valid` is high and `out_ready` is low, the output byte, `out_last` and `out_err` hold and `out_valid` stays high.
- R10: `frame_cnt` increases by one on each clock edge that accepts a last byte, and changes at no other time.
- R11: From idle, a control write that sets enable, presented in cycle t, makes the first byte valid in cycle t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpl_we | input | 1 | Template word write strobe |
| tpl_addr | input | 5 | Template word address (select * words + word) |
| tpl_wdata | input | 16 | Template word, first byte in bits [15:8] |
| len_we | input | 1 | Length write strobe |
| len_hdr | input | 11 | Header length in bytes |
| len_frame | input | 11 | Total frame length in bytes including FCS |
| len_rej | output | 1 | One-cycle pulse: last length write was rejected |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word (gap, select, mode, valid bits, enable) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| out_err | output | 1 | Final byte deliberately corrupted |
| frame_cnt | output | 16 | Number of completed frames, wrapping |

## Verification
A wrong byte index or a stale latched length shows up as a wrong `out_data` byte or a misplaced `out_last` within one frame, at most about a thousand cycles after the fault. A wrong gap counter or a wrong enable sampling makes `out_valid` rise a cycle early or late right after the frame's last transfer. A mode or select captured at the wrong moment is visible at the boundary of the frame during which the write arrived. The reference model predicts every output bit on every cycle, so any such divergence is reported on the first cycle it appears, including under random back-pressure.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

  // control word layout
  localparam int CTRL_W      = 32;
  localparam int CW_GAP_LSB  = 0;
  localparam int CW_GAP_W    = 16;
  localparam int CW_SEL_LSB  = 16;
  localparam int CW_SEL_W    = 2;
  localparam int CW_MODE_LSB = 18;
  localparam int CW_MODE_W   = 2;
  localparam int CW_CFGV     = 20;
  localparam int CW_MODEV    = 21;
  localparam int CW_ENA      = 22;

  // frame limits
  localparam int MIN_FRAME = 64;
  localparam int MAX_FRAME = 1024;
  localparam int FCS_BYTES = 4;

  // reset defaults
  localparam int RST_GAP  = 12;
  localparam int RST_HDR  = 14;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_SEND = 2'd1,
    GS_GAP  = 2'd2
  } gen_state_e;

  // only mode 1 damages frames; 2 and 3 behave as normal
  function automatic logic mode_corrupts(input logic [CW_MODE_W-1:0] m);
    return m == CW_MODE_W'(1);
  endfunction

endpackage

// File: rtl/tfg_ctrl_regs.sv
module tfg_ctrl_regs
  import tfg_pkg::*;
#(
  parameter int GAP_W   = 16,
  parameter int SEL_W   = 1,
  parameter int LEN_W   = 11,
  parameter int HDR_MAX = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic [CTRL_W-1:0]    ctrl_wdata,
  input  logic                 len_we,
  input  logic [LEN_W-1:0]     len_hdr,
  input  logic [LEN_W-1:0]     len_frame,
  output logic [GAP_W-1:0]     cfg_gap,
  output logic [SEL_W-1:0]     cfg_sel,
  output logic [CW_MODE_W-1:0] cfg_mode,
  output logic                 cfg_en,
  output logic [LEN_W-1:0]     cfg_hdr,
  output logic [LEN_W-1:0]     cfg_frame,
  output logic                 len_rej
);

  logic len_ok;
  logic unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_wdata[CTRL_W-1:CW_ENA+1],
                              ctrl_wdata[CW_SEL_LSB+CW_SEL_W-1:CW_SEL_LSB+SEL_W-1]};

  always_comb begin
    len_ok = !len_hdr[0]
          && (len_hdr   <= LEN_W'(HDR_MAX))
          && (len_frame >= LEN_W'(MIN_FRAME))
          && (len_frame <= LEN_W'(MAX_FRAME));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_gap  <= GAP_W'(RST_GAP);
      cfg_sel  <= '0;
      cfg_mode <= '0;
      cfg_en   <= 1'b0;
    end else if (ctrl_we) begin
      if (ctrl_wdata[CW_CFGV]) begin
        cfg_gap <= ctrl_wdata[CW_GAP_LSB +: GAP_W];
        cfg_sel <= ctrl_wdata[CW_SEL_LSB +: SEL_W];
      end
      if (ctrl_wdata[CW_MODEV])
        cfg_mode <= ctrl_wdata[CW_MODE_LSB +: CW_MODE_W];
      cfg_en <= ctrl_wdata[CW_ENA];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_hdr   <= LEN_W'(RST_HDR);
      cfg_frame <= LEN_W'(MIN_FRAME);
      len_rej   <= 1'b0;
    end else begin
      len_rej <= len_we && !len_ok;
      if (len_we && len_ok) begin
        cfg_hdr   <= len_hdr;
        cfg_frame <= len_frame;
      end
    end
  end

endmodule

// File: rtl/tfg_tpl_mem.sv
module tfg_tpl_mem #(
  parameter int NUM_TPL   = 2,
  parameter int TPL_WORDS = 16,
  parameter int SEL_W     = 1,
  parameter int AW        = 5,
  parameter int BYTE_AW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [15:0]        wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [BYTE_AW-1:0] rd_byte,
  output logic [7:0]         rd_data
);

  localparam int DEPTH = NUM_TPL * TPL_WORDS;

  logic [15:0]   mem [DEPTH];
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  generate
    if (NUM_TPL == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^rd_sel;
      assign rd_addr = AW'(rd_byte[BYTE_AW-1:1]);
    end else begin : g_multi
      assign rd_addr = AW'(rd_sel) * AW'(TPL_WORDS) + AW'(rd_byte[BYTE_AW-1:1]);
    end
  endgenerate

  always_comb begin
    rd_word = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 16'h0000;
    rd_data = rd_byte[0] ? rd_word[7:0] : rd_word[15:8];
  end

endmodule

// File: rtl/tfg_seq.sv
module tfg_seq
  import tfg_pkg::*;
#(
  parameter int GAP_W = 16,
  parameter int SEL_W = 1,
  parameter int LEN_W = 11,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic [GAP_W-1:0]     cfg_gap,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [CW_MODE_W-1:0] cfg_mode,
  input  logic [LEN_W-1:0]     cfg_hdr,
  input  logic [LEN_W-1:0]     cfg_frame,
  input  logic [7:0]           tpl_byte,
  output logic [SEL_W-1:0]     rd_sel,
  output logic [LEN_W-1:0]     rd_idx,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last,
  output logic                 out_err,
  output logic [CNT_W-1:0]     frame_cnt
);

  gen_state_e       state;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] act_hdr;
  logic [LEN_W-1:0] act_last;
  logic [GAP_W-1:0] act_gap;
  logic [GAP_W-1:0] gap_cnt;
  logic [SEL_W-1:0] act_sel;
  logic             act_bad;

  logic             sending;
  logic             at_last;
  logic             done;
  logic             gap_end;
  logic             do_load;
  logic [LEN_W-1:0] pay_cnt;
  logic [7:0]       base;

  always_comb begin
    sending  = (state == GS_SEND);
    at_last  = (idx == act_last);
    pay_cnt  = idx - act_hdr;
    base     = (idx < act_hdr) ? tpl_byte : pay_cnt[7:0];
    done     = sending && out_ready && at_last;
    gap_end  = (state == GS_GAP) && (gap_cnt == GAP_W'(1));
    do_load  = cfg_en && ((state == GS_IDLE) || gap_end ||
                          (done && (act_gap == '0)));
    out_valid = sending;
    out_last  = sending && at_last;
    out_err   = sending && at_last && act_bad;
    if (!sending)
      out_data = 8'h00;
    else if (at_last && act_bad)
      out_data = ~base;
    else
      out_data = base;
    rd_sel = act_sel;
    rd_idx = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= GS_IDLE;
      idx      <= '0;
      act_hdr  <= LEN_W'(RST_HDR);
      act_last <= LEN_W'(MIN_FRAME - FCS_BYTES - 1);
      act_gap  <= '0;
      gap_cnt  <= '0;
      act_sel  <= '0;
      act_bad  <= 1'b0;
    end else if (do_load) begin
      state    <= GS_SEND;
      idx      <= '0;
      act_hdr  <= cfg_hdr;
      act_last <= cfg_frame - LEN_W'(FCS_BYTES + 1);
      act_gap  <= cfg_gap;
      act_sel  <= cfg_sel;
      act_bad  <= mode_corrupts(cfg_mode);
    end else begin
      case (state)
        GS_SEND: begin
          if (out_ready) begin
            if (at_last) begin
              state   <= (act_gap == '0) ? GS_IDLE : GS_GAP;
              gap_cnt <= act_gap;
            end else begin
              idx <= idx + LEN_W'(1);
            end
          end
        end
        GS_GAP: begin
          if (gap_end) state <= GS_IDLE;
          else         gap_cnt <= gap_cnt - GAP_W'(1);
        end
        default: state <= GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frame_cnt <= '0;
    else if (done) frame_cnt <= frame_cnt + CNT_W'(1);
  end

endmodule

// File: rtl/testfrm_gen.sv
module testfrm_gen
  import tfg_pkg::*;
#(
  parameter int NUM_TPL   = 2,
  parameter int TPL_WORDS = 16,
  parameter int GAP_W     = 16,
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 16,
  localparam int SEL_W    = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
  localparam int TPL_AW   = $clog2(NUM_TPL * TPL_WORDS),
  localparam int BYTE_AW  = $clog2(TPL_WORDS * 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tpl_we,
  input  logic [TPL_AW-1:0] tpl_addr,
  input  logic [15:0]       tpl_wdata,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_hdr,
  input  logic [LEN_W-1:0]  len_frame,
  output logic              len_rej,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              out_err,
  output logic [CNT_W-1:0]  frame_cnt
);

  logic [GAP_W-1:0]     cfg_gap;
  logic [SEL_W-1:0]     cfg_sel;
  logic [CW_MODE_W-1:0] cfg_mode;
  logic                 cfg_en;
  logic [LEN_W-1:0]     cfg_hdr;
  logic [LEN_W-1:0]     cfg_frame;
  logic [SEL_W-1:0]     rd_sel;
  logic [LEN_W-1:0]     rd_idx;
  logic [7:0]           tpl_byte;
  logic                 unused_idx_hi;

  assign unused_idx_hi = ^rd_idx[LEN_W-1:BYTE_AW];

  tfg_ctrl_regs #(
    .GAP_W(GAP_W), .SEL_W(SEL_W), .LEN_W(LEN_W), .HDR_MAX(TPL_WORDS * 2)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .len_we(len_we), .len_hdr(len_hdr), .len_frame(len_frame),
    .cfg_gap(cfg_gap), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode), .cfg_en(cfg_en),
    .cfg_hdr(cfg_hdr), .cfg_frame(cfg_frame), .len_rej(len_rej)
  );

  tfg_tpl_mem #(
    .NUM_TPL(NUM_TPL), .TPL_WORDS(TPL_WORDS), .SEL_W(SEL_W),
    .AW(TPL_AW), .BYTE_AW(BYTE_AW)
  ) u_tpl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tpl_we), .wr_addr(tpl_addr), .wr_data(tpl_wdata),
    .rd_sel(rd_sel), .rd_byte(rd_idx[BYTE_AW-1:0]), .rd_data(tpl_byte)
  );

  tfg_seq #(
    .GAP_W(GAP_W), .SEL_W(SEL_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_gap(cfg_gap), .cfg_sel(cfg_sel), .cfg_mode(cfg_mode),
    .cfg_hdr(cfg_hdr), .cfg_frame(cfg_frame),
    .tpl_byte(tpl_byte), .rd_sel(rd_sel), .rd_idx(rd_idx),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_err(out_err), .frame_cnt(frame_cnt)
  );

endmodule

// File: rtl/tfg_chk.sv
module tfg_chk #(
  parameter int LEN_W = 11,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             len_we,
  input logic [LEN_W-1:0] len_hdr,
  input logic             len_rej,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             out_err,
  input logic [CNT_W-1:0] frame_cnt
);

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_err)));

  // R6
  err_only_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_last));

  // R10
  fcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (frame_cnt == $past(frame_cnt) + CNT_W'(1)));

  // R10
  fcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready && out_last) |=> $stable(frame_cnt));

  // R4
  odd_hdr_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_we && len_hdr[0]) |=> len_rej);

  // R4
  no_write_no_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_we |=> !len_rej);

endmodule

bind testfrm_gen tfg_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_hdr(len_hdr), .len_rej(len_rej),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .out_err(out_err), .frame_cnt(frame_cnt)
);

// File: tb/testfrm_gen_bench.sv
module testfrm_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tpl_we = 1'b0;
  logic [4:0]  tpl_addr = '0;
  logic [15:0] tpl_wdata = '0;
  logic        len_we = 1'b0;
  logic [10:0] len_hdr = '0;
  logic [10:0] len_frame = '0;
  logic        len_rej;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_err;
  logic [15:0] frame_cnt;

  always #2 clk = ~clk;

  testfrm_gen u_testfrm_gen (
    .clk(clk), .rst_n(rst_n),
    .tpl_we(tpl_we), .tpl_addr(tpl_addr), .tpl_wdata(tpl_wdata),
    .len_we(len_we), .len_hdr(len_hdr), .len_frame(len_frame), .len_rej(len_rej),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_err(out_err), .frame_cnt(frame_cnt)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned tb_tpl [2][32];
  int   s_gap, s_sel, s_mode, s_hdr, s_flen;
  bit   m_en, exp_rej;
  int   m_state;          // 0 idle, 1 sending, 2 gap
  int   m_gcnt, m_agap, m_ahdr, m_pos;
  int   m_fcnt;
  logic [9:0] mq [$];     // {err,last,data}
  logic [9:0] m_e;
  bit   m_ld, m_ok;

  task automatic build_frame();
    int n;
    byte unsigned b;
    n = s_flen - 4;
    mq.delete();
    for (int i = 0; i < n; i++) begin
      b = (i < s_hdr) ? tb_tpl[s_sel][i] : 8'((i - s_hdr) & 255);
      if (i == n - 1 && s_mode == 1) mq.push_back({1'b1, 1'b1, ~b});
      else mq.push_back({1'b0, (i == n - 1), b});
    end
    m_agap  = s_gap;
    m_ahdr  = s_hdr;
    m_pos   = 0;
    m_state = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s_gap = 12; s_sel = 0; s_mode = 0; s_hdr = 14; s_flen = 64;
      m_en = 0; exp_rej = 0; m_state = 0; m_gcnt = 0; m_agap = 0;
      m_ahdr = 14; m_pos = 0; m_fcnt = 0; mq.delete();
      for (int s = 0; s < 2; s++) for (int b = 0; b < 32; b++) tb_tpl[s][b] = 0;
    end else begin
      m_ld = 0;
      case (m_state)
        0: if (m_en) m_ld = 1;
        1: if (out_ready) begin
             m_e = mq.pop_front();
             m_pos++;
             if (m_e[8]) begin
               m_fcnt = (m_fcnt + 1) & 16'hFFFF;
               if (m_agap == 0) begin
                 if (m_en) m_ld = 1; else m_state = 0;
               end else begin
                 m_state = 2; m_gcnt = m_agap;
               end
             end
           end
        default: if (m_gcnt == 1) begin
                   if (m_en) m_ld = 1; else m_state = 0;
                 end else m_gcnt--;
      endcase
      if (m_ld) build_frame();
      if (ctrl_we) begin
        if (ctrl_wdata[20]) begin s_gap = ctrl_wdata[15:0]; s_sel = ctrl_wdata[16]; end
        if (ctrl_wdata[21]) s_mode = ctrl_wdata[19:18];
        m_en = ctrl_wdata[22];
      end
      if (len_we) begin
        m_ok = (len_hdr % 2 == 0) && (len_hdr <= 32) && (len_frame >= 64) && (len_frame <= 1024);
        if (m_ok) begin s_hdr = len_hdr; s_flen = len_frame; end
        exp_rej = !m_ok;
      end else exp_rej = 0;
      if (tpl_we) begin
        tb_tpl[tpl_addr / 16][2 * (tpl_addr % 16)]     = tpl_wdata[15:8];
        tb_tpl[tpl_addr / 16][2 * (tpl_addr % 16) + 1] = tpl_wdata[7:0];
      end
    end
  end

  // ---------------- per-cycle comparison and monitor ----------------
  int   bytes = 0, last_len = 0, frames_seen = 0, gap_run = 0, meas_gap = -1;
  int   valid_cnt = 0, stall_seen = 0;
  bit   last_err = 0, in_gap = 0, prev_stall = 0;
  logic [7:0] prev_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == (m_state == 1), "R7 out_valid", out_valid, (m_state == 1));
      if (out_valid && m_state == 1) begin
        chk(out_data == mq[0][7:0], (m_pos < m_ahdr) ? "R2 header byte" : "R3 payload byte",
            out_data, mq[0][7:0]);
        chk(out_last == mq[0][8], "R3 out_last", out_last, mq[0][8]);
        chk(out_err == mq[0][9], "R6 out_err", out_err, mq[0][9]);
      end
      chk(frame_cnt == 16'(m_fcnt), "R10 frame_cnt", frame_cnt, m_fcnt);
      chk(len_rej == exp_rej, "R4 len_rej", len_rej, exp_rej);
      if (prev_stall) begin
        stall_seen++;
        chk(out_valid && out_data == prev_data, "R9 stalled byte held", out_data, prev_data);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid) valid_cnt++;
      if (out_valid && in_gap) begin meas_gap = gap_run; in_gap = 0; end
      if (!out_valid && in_gap) gap_run++;
      if (out_valid && out_ready) begin
        bytes++;
        if (out_last) begin
          last_len = bytes; last_err = out_err; bytes = 0;
          frames_seen++; gap_run = 0; in_gap = 1;
        end
      end
    end
  end

  // ---------------- ready driver ----------------
  bit        rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // ---------------- stimulus tasks ----------------
  task automatic ctrl_wr(input int gap, input int sel, input int mode,
                         input bit cfgv, input bit modev, input bit ena);
    logic [31:0] w;
    w = '0;
    w[15:0] = 16'(gap); w[17:16] = 2'(sel); w[19:18] = 2'(mode);
    w[20] = cfgv; w[21] = modev; w[22] = ena;
    @(posedge clk); #1; ctrl_we = 1'b1; ctrl_wdata = w;
    @(posedge clk); #1; ctrl_we = 1'b0;
  endtask

  task automatic len_wr(input int h, input int f);
    @(posedge clk); #1; len_we = 1'b1; len_hdr = 11'(h); len_frame = 11'(f);
    @(posedge clk); #1; len_we = 1'b0;
  endtask

  task automatic tpl_wr(input int a, input logic [15:0] d);
    @(posedge clk); #1; tpl_we = 1'b1; tpl_addr = 5'(a); tpl_wdata = d;
    @(posedge clk); #1; tpl_we = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames_seen + n;
    while (frames_seen < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_midframe();
    while (!(out_valid && bytes >= 5)) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  int vc;
  initial begin
    logic [15:0] hdr0 [7];
    hdr0 = '{16'h0180, 16'hC200, 16'h0001, 16'h0211, 16'h2233, 16'h4455, 16'hDEED};
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(frame_cnt == 16'd0, "R1 frame_cnt after reset", frame_cnt, 0);
    chk(len_rej == 1'b0, "R1 len_rej after reset", len_rej, 0);

    for (int w = 0; w < 7; w++) tpl_wr(w, hdr0[w]);
    for (int w = 0; w < 16; w++) tpl_wr(16 + w, {8'(8'hA0 + 2 * w), 8'(8'hA1 + 2 * w)});
    len_wr(14, 64);

    // R11 start latency
    ctrl_wr(10, 0, 0, 1, 1, 1);
    @(negedge clk); chk(!out_valid, "R11 not yet valid at t+1", out_valid, 0);
    @(negedge clk); chk(out_valid, "R11 valid at t+2", out_valid, 1);

    wait_frames(3);
    chk(meas_gap == 10, "R7 gap of 10", meas_gap, 10);
    chk(last_len == 60, "R3 frame of 64 gives 60 bytes", last_len, 60);

    // R5 mode-only write: gap/select field ignored
    ctrl_wr(50, 1, 1, 0, 1, 1);
    wait_frames(2);
    chk(last_err == 1'b1, "R6 mode 1 corrupts", last_err, 1);
    chk(meas_gap == 10, "R5 gap kept without config-valid", meas_gap, 10);

    // R6 reserved mode behaves as normal
    ctrl_wr(0, 0, 3, 0, 1, 1);
    wait_frames(2);
    chk(last_err == 1'b0, "R6 mode 3 normal", last_err, 0);

    // R7 back-to-back, template 1, longer header
    len_wr(20, 100);
    ctrl_wr(0, 1, 0, 1, 0, 1);
    wait_frames(3);
    chk(meas_gap == 0, "R7 gap of 0", meas_gap, 0);
    chk(last_len == 96, "R3 frame of 100 gives 96 bytes", last_len, 96);

    // R4 rejections
    len_wr(15, 100);  @(negedge clk); chk(len_rej, "R4 odd header rejected", len_rej, 1);
    len_wr(20, 63);   @(negedge clk); chk(len_rej, "R4 frame 63 rejected", len_rej, 1);
    len_wr(20, 1025); @(negedge clk); chk(len_rej, "R4 frame 1025 rejected", len_rej, 1);
    len_wr(34, 100);  @(negedge clk); chk(len_rej, "R4 header 34 rejected", len_rej, 1);
    wait_frames(2);
    chk(last_len == 96, "R4 old length kept", last_len, 96);
    len_wr(32, 1024); @(negedge clk); chk(!len_rej, "R4 limits accepted", len_rej, 0);
    wait_frames(2);
    chk(last_len == 1020, "R4 frame 1024 gives 1020 bytes", last_len, 1020);
    len_wr(20, 100);

    // R8 mid-frame mode change applies next frame
    ctrl_wr(20, 1, 0, 1, 1, 1);
    wait_frames(2);
    wait_midframe();
    ctrl_wr(20, 1, 1, 0, 1, 1);
    wait_frames(1);
    chk(last_err == 1'b0, "R8 current frame unaffected", last_err, 0);
    wait_frames(1);
    chk(last_err == 1'b1, "R8 next frame corrupted", last_err, 1);

    // R9 random back-pressure
    rdy_rand = 1;
    wait_frames(6);
    rdy_rand = 0;
    chk(stall_seen > 0, "R9 stalls exercised", stall_seen, 1);

    // R8 disable mid-frame lets frame finish
    wait_midframe();
    ctrl_wr(20, 1, 0, 0, 0, 0);
    wait_frames(1);
    chk(last_len == 96, "R8 frame completed after disable", last_len, 96);
    vc = valid_cnt;
    repeat (200) @(negedge clk);
    chk(valid_cnt == vc, "R8 idle after disable", valid_cnt - vc, 0);

    // repeated enable / disable
    ctrl_wr(5, 0, 0, 1, 1, 1);
    wait_frames(2);
    ctrl_wr(5, 0, 0, 0, 0, 0);
    repeat (150) @(negedge clk);
    ctrl_wr(3, 0, 1, 1, 1, 1);
    wait_frames(2);
    ctrl_wr(3, 0, 0, 0, 0, 0);
    repeat (150) @(negedge clk);

    chk(frame_cnt == 16'(frames_seen), "R10 frame_cnt equals frames received",
        frame_cnt, frames_seen);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule